// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 or DDR3 memory interface. It walks the memory through its power-up command sequence once after reset. A one-cycle `start` pulse begins a run. At that edge the block captures the memory-type select and the address-map configuration: the column code, the row code, the decoding mode and the bus width. It then presents one command at a time on `cmd_code`/`cmd_bank` with `cmd_valid` held high. It moves on only when the command path answers with `cmd_ack`. Between commands it raises the DLL-reset and OCD-default flags that the mode-register words need.

From the captured configuration the block computes where the two bank-select bits sit in the memory address, and it drives that value on `bank_pos`. The first NOP is followed by a fixed power-up pause. The pause length is set in clock cycles from a clock-frequency parameter and a microsecond length, one for each memory type. When the final dummy write has been accepted, `done` rises. From that point the refresh timer may be loaded.

The controller walks these named states: IDLE, NOP1, WAIT, NOP2, PRE1, EMR2, EMR3, EMR1, MRS_DLL, PRE2, REF1, REF2, MRS_RUN, OCD_SET, OCD_EXIT, ZQ, NORMAL, DUMMY and DONE. Transitions:
- IDLE or DONE goes to NOP1 on start.
- A command state goes to the next state when its command is accepted.
- WAIT goes to NOP2 when the pause counter runs out.
- NOP2 goes to PRE1 for DDR2 and to EMR2 for DDR3.
- MRS_DLL goes to PRE2 for DDR2 and to ZQ for DDR3.
- The DDR2 path then runs PRE2, REF1, REF2, MRS_RUN, OCD_SET and OCD_EXIT, and reaches NORMAL.
- ZQ goes to NORMAL.
- NORMAL goes to DUMMY, and DUMMY goes to DONE.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset `busy`, `done`, `cmd_valid`, `dll_reset` and `ocd_default` are all low, and they stay low until `start`.
- R2: Command codes are NOP=0, precharge-all=1, mode set=2, extended mode set=3, refresh=4, ZQ calibration=5, normal mode=6 and dummy write=7. A command is accepted in a cycle where `cmd_valid` and `cmd_ack` are both high. Until then `cmd_valid`, `cmd_code` and `cmd_bank` hold steady.
- R3: `bank_pos` equals col_code + 9, plus row_code + 11 when `seq_map` is 1, plus 1 when `narrow_bus` is 1 or plus 2 when it is 0. It uses the configuration captured at `start`.
- R4: Each run opens with a NOP, then a pause, then a second NOP. During the pause `cmd_valid` is low for exactly CLK_MHZ×DDR2_WAIT_US cycles (DDR2) or CLK_MHZ×DDR3_WAIT_US cycles (DDR3). For DDR2 a precharge-all follows the second NOP.
- R5: The extended mode sets are issued with banks 2, 3 and then 1.
- R6: Next comes a mode set with bank 0 and `dll_reset`=1. For DDR2, `dll_reset` stays high through a precharge-all and exactly two refreshes, then drops for a second mode set with bank 0.
- R7: For DDR2, an extended mode set with bank 1 is issued with `ocd_default`=1. It is followed by another extended mode set with bank 1 and `ocd_default`=0.
- R8: For DDR3, a ZQ calibration follows the DLL-reset mode set, with both flags low.
- R9: Every run ends with a normal-mode command and then a dummy write. `done` rises, and `busy` falls, in the cycle after the dummy write is accepted.
- R10: A `start` pulse while `busy` is high changes neither the sequence nor `bank_pos`. `done` stays high until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle or done |
| ddr3_sel | input | 1 | 1 selects DDR3, 0 selects DDR2 |
| col_code | input | 2 | Column-bit code |
| row_code | input | 2 | Row-bit code |
| seq_map | input | 1 | 1 selects sequential address decoding |
| narrow_bus | input | 1 | 1 selects the narrow data bus |
| cmd_ack | input | 1 | Command path accepts the current command |
| cmd_valid | output | 1 | A command is presented |
| cmd_code | output | 3 | Command code |
| cmd_bank | output | 2 | Bank value for the command |
| dll_reset | output | 1 | DLL-reset flag |
| ocd_default | output | 1 | OCD-default flag |
| bank_pos | output | 5 | Address bit where the bank field starts |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Initialization complete; refresh timer may be loaded |

## Verification
A start pulse driven at a falling edge shows up as the first NOP at the next falling edge, one register later. The bench checks `bank_pos` at that same point. An accepted command is recorded at the falling edge where the bench raises `cmd_ack`, because the design leaves the state at the next rising edge. The next command therefore appears one falling edge later. The pause is measured as the number of falling edges with `cmd_valid` low between acceptance of the first NOP and arrival of the second. `done` is sampled exactly one falling edge after the dummy write is accepted.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    localparam int COL_CODE_W = 2;
    localparam int ROW_CODE_W = 2;
    localparam int BANK_W     = 2;
    localparam int POS_W      = 5;
    localparam int COL_BASE   = 9;
    localparam int ROW_BASE   = 11;

    typedef enum logic [2:0] {
        CMD_NOP      = 3'd0,
        CMD_PRE_ALL  = 3'd1,
        CMD_MODE     = 3'd2,
        CMD_EXT_MODE = 3'd3,
        CMD_REFRESH  = 3'd4,
        CMD_ZQ_CAL   = 3'd5,
        CMD_NORMAL   = 3'd6,
        CMD_DUMMY_WR = 3'd7
    } sdram_cmd_e;

    typedef enum logic [4:0] {
        S_IDLE, S_NOP1, S_WAIT, S_NOP2, S_PRE1, S_EMR2, S_EMR3, S_EMR1,
        S_MRS_DLL, S_PRE2, S_REF1, S_REF2, S_MRS_RUN, S_OCD_SET,
        S_OCD_EXIT, S_ZQ, S_NORMAL, S_DUMMY, S_DONE
    } init_state_e;

endpackage

// File: rtl/bank_pos_calc.sv
module bank_pos_calc
    import sdram_init_pkg::*;
(
    input  logic [COL_CODE_W-1:0] col_code,
    input  logic [ROW_CODE_W-1:0] row_code,
    input  logic                  seq_map,
    input  logic                  narrow_bus,
    output logic [POS_W-1:0]      bank_pos
);
    logic [POS_W-1:0] row_part;
    logic [POS_W-1:0] bus_part;

    always_comb begin
        row_part = seq_map ? (POS_W'(row_code) + POS_W'(ROW_BASE)) : '0;
        bus_part = narrow_bus ? POS_W'(1) : POS_W'(2);
        bank_pos = POS_W'(col_code) + POS_W'(COL_BASE) + row_part + bus_part;
    end
endmodule

// File: rtl/init_delay_timer.sv
module init_delay_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ      = 250,
    parameter int DDR2_WAIT_US = 200,
    parameter int DDR3_WAIT_US = 500
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  ddr3_sel,
    input  logic [COL_CODE_W-1:0] col_code,
    input  logic [ROW_CODE_W-1:0] row_code,
    input  logic                  seq_map,
    input  logic                  narrow_bus,
    input  logic                  cmd_ack,
    output logic                  cmd_valid,
    output logic [2:0]            cmd_code,
    output logic [BANK_W-1:0]     cmd_bank,
    output logic                  dll_reset,
    output logic                  ocd_default,
    output logic [POS_W-1:0]      bank_pos,
    output logic                  busy,
    output logic                  done
);
    localparam int DDR2_CYC = CLK_MHZ * DDR2_WAIT_US;
    localparam int DDR3_CYC = CLK_MHZ * DDR3_WAIT_US;
    localparam int MAX_CYC  = (DDR2_CYC > DDR3_CYC) ? DDR2_CYC : DDR3_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    init_state_e state, state_nx;
    logic                  is_ddr3;
    logic [COL_CODE_W-1:0] col_q;
    logic [ROW_CODE_W-1:0] row_q;
    logic                  seq_q, narrow_q;
    logic                  accept, launch, wait_over, tmr_load;
    logic [CNT_W-1:0]      tmr_val;
    sdram_cmd_e            cmd_e;

    assign accept   = cmd_valid & cmd_ack;
    assign launch   = start & ((state == S_IDLE) | (state == S_DONE));
    assign tmr_load = (state == S_NOP1) & accept;
    assign tmr_val  = is_ddr3 ? CNT_W'(DDR3_CYC - 1) : CNT_W'(DDR2_CYC - 1);

    init_delay_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (wait_over)
    );

    bank_pos_calc u_pos (
        .col_code   (col_q),
        .row_code   (row_q),
        .seq_map    (seq_q),
        .narrow_bus (narrow_q),
        .bank_pos   (bank_pos)
    );

    // State register and configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            is_ddr3  <= 1'b0;
            col_q    <= '0;
            row_q    <= '0;
            seq_q    <= 1'b0;
            narrow_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (launch) begin
                is_ddr3  <= ddr3_sel;
                col_q    <= col_code;
                row_q    <= row_code;
                seq_q    <= seq_map;
                narrow_q <= narrow_bus;
            end
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE, S_DONE: if (launch) state_nx = S_NOP1;
            S_NOP1:     if (accept) state_nx = S_WAIT;
            S_WAIT:     if (wait_over) state_nx = S_NOP2;
            S_NOP2:     if (accept) state_nx = is_ddr3 ? S_EMR2 : S_PRE1;
            S_PRE1:     if (accept) state_nx = S_EMR2;
            S_EMR2:     if (accept) state_nx = S_EMR3;
            S_EMR3:     if (accept) state_nx = S_EMR1;
            S_EMR1:     if (accept) state_nx = S_MRS_DLL;
            S_MRS_DLL:  if (accept) state_nx = is_ddr3 ? S_ZQ : S_PRE2;
            S_PRE2:     if (accept) state_nx = S_REF1;
            S_REF1:     if (accept) state_nx = S_REF2;
            S_REF2:     if (accept) state_nx = S_MRS_RUN;
            S_MRS_RUN:  if (accept) state_nx = S_OCD_SET;
            S_OCD_SET:  if (accept) state_nx = S_OCD_EXIT;
            S_OCD_EXIT: if (accept) state_nx = S_NORMAL;
            S_ZQ:       if (accept) state_nx = S_NORMAL;
            S_NORMAL:   if (accept) state_nx = S_DUMMY;
            S_DUMMY:    if (accept) state_nx = S_DONE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_valid   = 1'b1;
        cmd_e       = CMD_NOP;
        cmd_bank    = '0;
        dll_reset   = 1'b0;
        ocd_default = 1'b0;
        unique case (state)
            S_IDLE, S_WAIT, S_DONE: cmd_valid = 1'b0;
            S_NOP1, S_NOP2:         cmd_e = CMD_NOP;
            S_PRE1:                 cmd_e = CMD_PRE_ALL;
            S_EMR2: begin cmd_e = CMD_EXT_MODE; cmd_bank = 2'd2; end
            S_EMR3: begin cmd_e = CMD_EXT_MODE; cmd_bank = 2'd3; end
            S_EMR1, S_OCD_EXIT: begin cmd_e = CMD_EXT_MODE; cmd_bank = 2'd1; end
            S_OCD_SET: begin
                cmd_e = CMD_EXT_MODE; cmd_bank = 2'd1; ocd_default = 1'b1;
            end
            S_MRS_DLL: begin cmd_e = CMD_MODE; dll_reset = 1'b1; end
            S_PRE2:    begin cmd_e = CMD_PRE_ALL; dll_reset = 1'b1; end
            S_REF1, S_REF2: begin cmd_e = CMD_REFRESH; dll_reset = 1'b1; end
            S_MRS_RUN: cmd_e = CMD_MODE;
            S_ZQ:      cmd_e = CMD_ZQ_CAL;
            S_NORMAL:  cmd_e = CMD_NORMAL;
            S_DUMMY:   cmd_e = CMD_DUMMY_WR;
            default:   cmd_valid = 1'b0;
        endcase
    end

    assign cmd_code = cmd_e;
    assign busy     = (state != S_IDLE) && (state != S_DONE);
    assign done     = (state == S_DONE);

    // Checks on the sequencer
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmd_valid && !dll_reset && !ocd_default));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_bank)));

    p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bank_pos >= POS_W'(10) && bank_pos <= POS_W'(28)));

    p_ext_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_EXT_MODE) |-> (cmd_bank != '0));

    p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(dll_reset && ocd_default));

    p_ocd_emr1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ocd_default |-> (cmd_valid && cmd_code == CMD_EXT_MODE && cmd_bank == 2'd1));

    p_done_after_dummy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(accept && cmd_code == CMD_DUMMY_WR));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(bank_pos));
endmodule

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, ddr3_sel = 1'b0, seq_map = 1'b0, narrow_bus = 1'b0;
    logic [1:0] col_code = '0, row_code = '0;
    logic cmd_ack = 1'b0;
    logic cmd_valid, dll_reset, ocd_default, busy, done;
    logic [2:0] cmd_code;
    logic [1:0] cmd_bank;
    logic [4:0] bank_pos;

    always #2 clk = ~clk;

    sdram_init_seq #(.CLK_MHZ(2)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ddr3_sel(ddr3_sel),
        .col_code(col_code), .row_code(row_code), .seq_map(seq_map),
        .narrow_bus(narrow_bus), .cmd_ack(cmd_ack), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .dll_reset(dll_reset),
        .ocd_default(ocd_default), .bank_pos(bank_pos), .busy(busy), .done(done)
    );

    typedef struct packed {
        logic [2:0] code;
        logic [1:0] bank;
        logic       dll;
        logic       ocd;
    } item_t;

    item_t sb_q[$];
    string tag_q[$];
    int n_chk = 0, n_fail = 0;
    int ack_delay = 0, ack_wait = 0;
    int exp_wait = 0, gap_cnt = 0, nop_seen = 0;
    bit gap_on = 0, done_due = 0, pend = 0, finished = 0;
    logic [2:0] pend_code;
    logic [1:0] pend_bank;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] c, input logic [1:0] b,
                        input logic d, input logic o, input string req);
        sb_q.push_back('{code: c, bank: b, dll: d, ocd: o});
        tag_q.push_back(req);
    endtask

    // Monitor: drives the acknowledge and scores each accepted command
    always @(negedge clk) begin
        if (rst_n) begin
            if (gap_on) begin
                if (!cmd_valid) gap_cnt++;
                else begin
                    chk(gap_cnt == exp_wait, "R4 pause", gap_cnt, exp_wait);
                    gap_on = 0;
                end
            end
            if (done_due) begin
                chk(done && !busy, "R9 done", {30'd0, done, busy}, 2);
                done_due = 0;
            end
            if (cmd_valid) begin
                if (pend)
                    chk(cmd_code == pend_code && cmd_bank == pend_bank, "R2 hold",
                        {27'd0, cmd_code, cmd_bank}, {27'd0, pend_code, pend_bank});
                if (ack_wait >= ack_delay) begin
                    item_t e;
                    string t;
                    item_t a;
                    cmd_ack = 1'b1;
                    ack_wait = 0;
                    pend = 0;
                    a = '{code: cmd_code, bank: cmd_bank, dll: dll_reset, ocd: ocd_default};
                    if (sb_q.size() == 0) begin
                        chk(0, "R2 extra command", int'(a), -1);
                    end else begin
                        e = sb_q.pop_front();
                        t = tag_q.pop_front();
                        chk(a == e, t, int'(a), int'(e));
                        if (e.code == 3'd0 && nop_seen == 0) begin
                            gap_on = 1;
                            gap_cnt = 0;
                        end
                        if (e.code == 3'd0) nop_seen++;
                        if (sb_q.size() == 0) begin
                            chk(!done, "R9 done early", int'(done), 0);
                            done_due = 1;
                        end
                    end
                end else begin
                    cmd_ack = 1'b0;
                    ack_wait++;
                    pend = 1;
                    pend_code = cmd_code;
                    pend_bank = cmd_bank;
                end
            end else begin
                if (pend) chk(0, "R2 valid dropped", 0, 1);
                pend = 0;
                cmd_ack = 1'b0;
            end
        end
    end

    // Driver: queues the expected sequence and starts a run
    task automatic run_seq(input bit d3, input logic [1:0] col, input logic [1:0] row,
                           input bit sq, input bit nb, input int adly, input int exp_pos,
                           input bit poke);
        ack_delay = adly;
        ack_wait = 0;
        nop_seen = 0;
        exp_wait = d3 ? 1000 : 400;
        push(3'd0, 2'd0, 0, 0, "R4 nop1");
        push(3'd0, 2'd0, 0, 0, "R4 nop2");
        if (!d3) push(3'd1, 2'd0, 0, 0, "R4 precharge");
        push(3'd3, 2'd2, 0, 0, "R5 emr2");
        push(3'd3, 2'd3, 0, 0, "R5 emr3");
        push(3'd3, 2'd1, 0, 0, "R5 emr1");
        push(3'd2, 2'd0, 1, 0, "R6 mrs dll");
        if (!d3) begin
            push(3'd1, 2'd0, 1, 0, "R6 precharge");
            push(3'd4, 2'd0, 1, 0, "R6 refresh1");
            push(3'd4, 2'd0, 1, 0, "R6 refresh2");
            push(3'd2, 2'd0, 0, 0, "R6 mrs clear");
            push(3'd3, 2'd1, 0, 1, "R7 ocd set");
            push(3'd3, 2'd1, 0, 0, "R7 ocd exit");
        end else begin
            push(3'd5, 2'd0, 0, 0, "R8 zq");
        end
        push(3'd6, 2'd0, 0, 0, "R9 normal");
        push(3'd7, 2'd0, 0, 0, "R9 dummy");
        ddr3_sel = d3; col_code = col; row_code = row; seq_map = sq; narrow_bus = nb;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, "R10 new run", {30'd0, busy, done}, 2);
        chk(bank_pos == 5'(exp_pos), "R3 bank pos", int'(bank_pos), exp_pos);
        if (poke) begin
            repeat (20) @(negedge clk);
            col_code = 2'd0; seq_map = ~sq; ddr3_sel = ~d3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            chk(bank_pos == 5'(exp_pos), "R10 start ignored", int'(bank_pos), exp_pos);
        end
        while (sb_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(done && !cmd_valid, "R10 done holds", {30'd0, done, cmd_valid}, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !cmd_valid && !dll_reset && !ocd_default, "R1 in reset",
            {27'd0, busy, done, cmd_valid, dll_reset, ocd_default}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !cmd_valid, "R1 idle", {29'd0, busy, done, cmd_valid}, 0);
        run_seq(1'b0, 2'd1, 2'd2, 1'b1, 1'b0, 0, 25, 1'b0);
        run_seq(1'b1, 2'd2, 2'd1, 1'b0, 1'b1, 2, 12, 1'b1);
        run_seq(1'b0, 2'd3, 2'd3, 1'b1, 1'b1, 1, 27, 1'b1);
        run_seq(1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 0, 22, 1'b0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule